// File: doc/BRIEF.md
# Floating-Point Min/Max Special-Case Selector

This block computes the minimum or maximum of two 32-bit binary floating-point operands for one vector lane. Beyond ordinary numeric ordering it implements five selectable semantics that disagree on what to do with NaN operands and with pairs of zeros. These are an IEEE minNum/maxNum style, a Java-style, a C-macro-style, a C++-style and an F-style. Any of them can be run on the absolute values of the operands. Each operand is classified as negative, zero, NaN or signaling NaN. A decision stage then chooses operand A, operand B, a quieted copy of either, or the plain numeric result, and raises an invalid-operation flag where the chosen semantics demand it.

A request is presented with `en_i` high and is answered one clock later with `valid_o`. The result, the invalid flag and an illegal-type indication are held in registers until the next request.

Top module: `fmm_unit`

## Requirements
- R1: `mode_i[2:0]` selects the semantics: 0 IEEE, 1 Java, 2 C-macro, 3 C++, 4 F-style. The codes 5, 6 and 7 behave exactly as code 0 and set `bad_type_o`. For codes 0 to 4, `bad_type_o` is 0.
- R2: When `mode_i[3]` is 1, bit 31 of both operands is cleared before any other step, so the result always has bit 31 equal to 0.
- R3: If either operand is a signaling NaN, `invalid_o` is 1 for every type. A NaN is signaling when its exponent is all ones, its fraction is nonzero and fraction bit 22 is 0. A NaN is quieted by setting bit 22.
- R4: Java-style with any NaN operand returns A quieted if A is signaling. Otherwise it returns B quieted if B is signaling. Otherwise it returns A if A is a NaN, and B if not.
- R5: F-style with any NaN operand returns A if B is a NaN, else B, with no quieting.
- R6: With any NaN operand, C-macro-style returns B and C++-style returns A, and both set `invalid_o` even for quiet NaNs.
- R7: For a minimum of two zeros, IEEE, Java and F-style return A if A is negative, else B. C-macro returns B and C++ returns A.
- R8: For a maximum of two zeros, IEEE, Java and F-style return B if A is negative, else A. C-macro returns B and C++ returns A.
- R9: Otherwise (no NaN, not both zero) the result is the numerically smaller (`is_min_i`=1) or larger operand, ordering values by sign and magnitude with infinities at the ends.
- R10: IEEE type with NaNs returns A quieted if A is signaling. Otherwise it returns B quieted if B is signaling. Otherwise, when exactly one operand is a NaN, it returns the other operand, and when both are, it returns A.
- R11: Outputs update on the clock edge after a cycle with `en_i`=1, with `valid_o` high for that one cycle. With `en_i`=0, the result and flags hold. Reset clears all outputs.
- R12: `invalid_o` is 0 whenever neither operand is a NaN. For IEEE, Java and F-style, it is 0 when the only NaNs are quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Request strobe |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| is_min_i | input | 1 | 1 selects minimum, 0 maximum |
| mode_i | input | 4 | Bits 2:0 semantics type, bit 3 absolute-value mode |
| valid_o | output | 1 | Result valid, one cycle after request |
| res_o | output | 32 | Selected result |
| invalid_o | output | 1 | Invalid-operation flag |
| bad_type_o | output | 1 | Reserved type code was used |

## Verification
The assertions check on every cycle that the invalid flag never rises without a NaN among the classified operands, and that a signaling NaN always raises it. They also check that absolute-value mode never produces a set sign bit, that a reserved code is flagged, and that the result holds and `valid_o` follows `en_i` with one cycle of delay. Which operand each semantics returns for NaNs and signed zeros, and the numeric ordering across signs and infinities, can only be shown by the bench. It compares every result against an independently written model. Its operand mix is biased toward zeros, infinities and both kinds of NaN.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  parameter int FP_W  = 32;
  parameter int EXP_W = 8;
  localparam int MAN_W = FP_W - EXP_W - 1;
  localparam int QBIT  = MAN_W - 1;
  localparam int TYPE_W = 3;

  typedef enum logic [TYPE_W-1:0] {
    SEM_IEEE = 3'd0, SEM_JAVA = 3'd1, SEM_CMAC = 3'd2,
    SEM_CPP  = 3'd3, SEM_FSTY = 3'd4
  } sem_e;

  typedef enum logic [2:0] {
    PICK_NUM, PICK_A, PICK_B, PICK_QA, PICK_QB
  } pick_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic nan;
    logic snan;
  } fcls_t;

  function automatic fcls_t fp_classify(input logic [FP_W-1:0] x);
    fcls_t c;
    logic exp_ones, man_zero;
    exp_ones = &x[FP_W-2 -: EXP_W];
    man_zero = ~|x[MAN_W-1:0];
    c.neg  = x[FP_W-1];
    c.zero = (~|x[FP_W-2:0]);
    c.nan  = exp_ones & ~man_zero;
    c.snan = c.nan & ~x[QBIT];
    return c;
  endfunction

  function automatic logic [FP_W-1:0] fp_quiet(input logic [FP_W-1:0] x);
    logic [FP_W-1:0] r;
    r = x;
    r[QBIT] = 1'b1;
    return r;
  endfunction

  // Sign-magnitude ordering: 1 when a is strictly below b.
  function automatic logic fp_less(input logic [FP_W-1:0] a,
                                   input logic [FP_W-1:0] b);
    logic [FP_W-2:0] ma, mb;
    ma = a[FP_W-2:0];
    mb = b[FP_W-2:0];
    if (a[FP_W-1] != b[FP_W-1]) return a[FP_W-1];
    else if (a[FP_W-1])         return ma > mb;
    else                        return ma < mb;
  endfunction
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  output fcls_t           cls_o
);
  always_comb cls_o = fp_classify(val_i);
endmodule

// File: rtl/fmm_pick.sv
module fmm_pick
  import fmm_pkg::*;
(
  input  fcls_t cls_a_i,
  input  fcls_t cls_b_i,
  input  sem_e  sem_i,
  input  logic  is_min_i,
  output pick_e pick_o,
  output logic  inv_o
);
  logic any_nan, any_snan, both_zero, neg_first;

  always_comb begin
    any_nan   = cls_a_i.nan | cls_b_i.nan;
    any_snan  = cls_a_i.snan | cls_b_i.snan;
    both_zero = cls_a_i.zero & cls_b_i.zero;
    neg_first = is_min_i ? cls_a_i.neg : ~cls_a_i.neg;
    pick_o = PICK_NUM;
    inv_o  = any_snan;
    if (any_nan) begin
      unique case (sem_i)
        SEM_JAVA, SEM_IEEE: begin
          if (cls_a_i.snan)      pick_o = PICK_QA;
          else if (cls_b_i.snan) pick_o = PICK_QB;
          else if (sem_i == SEM_JAVA)
            pick_o = cls_a_i.nan ? PICK_A : PICK_B;
          else
            pick_o = (cls_a_i.nan && !cls_b_i.nan) ? PICK_B : PICK_A;
        end
        SEM_FSTY: pick_o = cls_b_i.nan ? PICK_A : PICK_B;
        SEM_CMAC: begin pick_o = PICK_B; inv_o = 1'b1; end
        SEM_CPP:  begin pick_o = PICK_A; inv_o = 1'b1; end
        default:  pick_o = PICK_A;
      endcase
    end else if (both_zero) begin
      unique case (sem_i)
        SEM_CMAC: pick_o = PICK_B;
        SEM_CPP:  pick_o = PICK_A;
        default:  pick_o = neg_first ? PICK_A : PICK_B;
      endcase
    end
  end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
  import fmm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [FP_W-1:0]  opa_i,
  input  logic [FP_W-1:0]  opb_i,
  input  logic             is_min_i,
  input  logic [TYPE_W:0]  mode_i,
  output logic             valid_o,
  output logic [FP_W-1:0]  res_o,
  output logic             invalid_o,
  output logic             bad_type_o
);
  localparam int NOPS = 2;

  logic            abs_mode_w, reserved_w;
  sem_e            sem_w;
  logic [FP_W-1:0] opnd_w [NOPS];
  fcls_t           cls_w  [NOPS];
  pick_e           pick_w;
  logic            flag_inv_w, any_nan_w, any_snan_w;
  logic [FP_W-1:0] sel_w;

  always_comb begin
    abs_mode_w = mode_i[TYPE_W];
    reserved_w = mode_i[TYPE_W-1:0] > SEM_FSTY;
    sem_w      = reserved_w ? SEM_IEEE : sem_e'(mode_i[TYPE_W-1:0]);
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    logic [FP_W-1:0] raw;
    assign raw = (g == 0) ? opa_i : opb_i;
    assign opnd_w[g] = abs_mode_w ? {1'b0, raw[FP_W-2:0]} : raw;
    fmm_classify u_cls (.val_i(opnd_w[g]), .cls_o(cls_w[g]));
  end

  assign any_nan_w  = cls_w[0].nan  | cls_w[1].nan;
  assign any_snan_w = cls_w[0].snan | cls_w[1].snan;

  fmm_pick u_pick (
    .cls_a_i (cls_w[0]),
    .cls_b_i (cls_w[1]),
    .sem_i   (sem_w),
    .is_min_i(is_min_i),
    .pick_o  (pick_w),
    .inv_o   (flag_inv_w)
  );

  always_comb begin
    unique case (pick_w)
      PICK_A:  sel_w = opnd_w[0];
      PICK_B:  sel_w = opnd_w[1];
      PICK_QA: sel_w = fp_quiet(opnd_w[0]);
      PICK_QB: sel_w = fp_quiet(opnd_w[1]);
      default: sel_w = (fp_less(opnd_w[0], opnd_w[1]) == is_min_i)
                       ? opnd_w[0] : opnd_w[1];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o    <= 1'b0;
      res_o      <= '0;
      invalid_o  <= 1'b0;
      bad_type_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        res_o      <= sel_w;
        invalid_o  <= flag_inv_w;
        bad_type_o <= reserved_w;
      end
    end
  end

  // R12
  inv_needs_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inv_w |-> any_nan_w);

  // R3
  snan_raises_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_snan_w |-> flag_inv_w);

  // R2
  abs_sign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i[TYPE_W]) |=> !res_o[FP_W-1]);

  // R1
  reserved_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i[TYPE_W-1:0] > 3'd4) |=> bad_type_o);

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> valid_o);

  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(res_o) && $stable(invalid_o) && !valid_o));
endmodule

// File: tb/fmm_unit_tb.sv
module fmm_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        is_min_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic        valid_o, invalid_o, bad_type_o;
  logic [31:0] res_o;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  fmm_unit u_dut (.clk, .rst_n, .en_i, .opa_i, .opb_i, .is_min_i, .mode_i,
                  .valid_o, .res_o, .invalid_o, .bad_type_o);

  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7fc0_0001, SN = 32'h7f80_0005;

  function automatic bit is_nan(logic [31:0] x);
    return x[30:23] == 8'hff && x[22:0] != 0;
  endfunction
  function automatic bit is_sig(logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction
  function automatic bit is_z(logic [31:0] x);
    return x[30:0] == 0;
  endfunction
  function automatic logic [31:0] order_key(logic [31:0] x);
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  // Reference model written from the requirement list.
  function automatic logic [32:0] model(logic [31:0] a0, logic [31:0] b0,
                                        bit mn, logic [3:0] md);
    logic [31:0] a, b, r;
    bit inv;
    int t;
    t = md[2:0];
    if (t > 4) t = 0;
    a = md[3] ? (a0 & 32'h7fff_ffff) : a0;
    b = md[3] ? (b0 & 32'h7fff_ffff) : b0;
    inv = is_sig(a) || is_sig(b);
    if (is_nan(a) || is_nan(b)) begin
      if (t == 2) begin r = b; inv = 1; end
      else if (t == 3) begin r = a; inv = 1; end
      else if (t == 4) r = is_nan(b) ? a : b;
      else if (is_sig(a)) r = a | 32'h0040_0000;
      else if (is_sig(b)) r = b | 32'h0040_0000;
      else if (t == 1) r = is_nan(a) ? a : b;
      else r = is_nan(b) ? a : b;
    end else if (is_z(a) && is_z(b)) begin
      if (t == 2) r = b;
      else if (t == 3) r = a;
      else if (mn) r = a[31] ? a : b;
      else r = a[31] ? b : a;
    end else begin
      if (mn) r = (order_key(a) < order_key(b)) ? a : b;
      else    r = (order_key(a) > order_key(b)) ? a : b;
    end
    return {inv, r};
  endfunction

  function automatic string tag_of(logic [31:0] a, logic [31:0] b, bit mn,
                                   logic [3:0] md);
    logic [31:0] x, y;
    x = md[3] ? (a & 32'h7fff_ffff) : a;
    y = md[3] ? (b & 32'h7fff_ffff) : b;
    if (md[2:0] > 4) return "R1";
    if (is_nan(x) || is_nan(y)) begin
      case (md[2:0])
        3'd1: return "R4";
        3'd4: return "R5";
        3'd0: return "R10";
        default: return "R6";
      endcase
    end
    if (is_z(x) && is_z(y)) return mn ? "R7" : "R8";
    if (md[3]) return "R2";
    return "R9";
  endfunction

  task automatic check(string tag, string what, logic [31:0] act,
                       logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] a, logic [31:0] b, bit mn,
                        logic [3:0] md, string tag);
    logic [32:0] e;
    e = model(a, b, mn, md);
    opa_i = a; opb_i = b; is_min_i = mn; mode_i = md; en_i = 1'b1;
    @(negedge clk);
    en_i = 1'b0;
    check(tag, "result", res_o, e[31:0]);
    check(is_sig(md[3] ? (a & 32'h7fff_ffff) : a) ||
          is_sig(md[3] ? (b & 32'h7fff_ffff) : b) ? "R3" : "R12",
          "invalid", {31'd0, invalid_o}, {31'd0, e[32]});
    check("R1", "bad_type", {31'd0, bad_type_o}, {31'd0, md[2:0] > 3'd4});
    check("R11", "valid", {31'd0, valid_o}, 32'd1);
  endtask

  function automatic logic [31:0] rand_opnd();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0: return PZ;
      1: return NZ;
      2: return {r[31], 8'hff, 1'b1, r[21:0]};
      3: return {r[31], 8'hff, 1'b0, r[21:1], 1'b1};
      4: return {r[31], 8'hff, 23'd0};
      5: return {r[31], 8'h7f, r[22:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11", "reset result", res_o, 32'd0);
    check("R11", "reset valid", {31'd0, valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_op(SN, QN, 1'b1, 4'd1, "R4");
    run_op(QN, SN, 1'b0, 4'd1, "R4");
    run_op(32'h3f80_0000, QN, 1'b1, 4'd1, "R4");
    run_op(QN, QN | 32'h8000_0000, 1'b1, 4'd4, "R5");
    run_op(QN, 32'h3f80_0000, 1'b1, 4'd4, "R5");
    run_op(QN, 32'h3f80_0000, 1'b1, 4'd2, "R6");
    run_op(QN, 32'h3f80_0000, 1'b0, 4'd3, "R6");
    run_op(NZ, PZ, 1'b1, 4'd1, "R7");
    run_op(PZ, NZ, 1'b1, 4'd4, "R7");
    run_op(NZ, PZ, 1'b1, 4'd2, "R7");
    run_op(NZ, PZ, 1'b0, 4'd1, "R8");
    run_op(PZ, NZ, 1'b0, 4'd3, "R8");
    run_op(32'hbf80_0000, 32'h4000_0000, 1'b1, 4'd0, "R9");
    run_op(32'hff80_0000, 32'hc000_0000, 1'b0, 4'd2, "R9");
    run_op(32'hc040_0000, 32'h4000_0000, 1'b1, 4'd9, "R2");
    run_op(32'hc040_0000, SN | 32'h8000_0000, 1'b1, 4'd8, "R2");
    run_op(QN, 32'h4000_0000, 1'b1, 4'd0, "R10");
    run_op(32'h4000_0000, SN, 1'b0, 4'd0, "R10");
    run_op(QN, 32'h4000_0000, 1'b1, 4'd6, "R1");
    run_op(NZ, PZ, 1'b1, 4'd15, "R1");

    // R11: idle cycle holds outputs and drops valid
    held = res_o;
    opa_i = 32'h1234_5678; opb_i = 32'h0; mode_i = 4'd3;
    @(negedge clk);
    check("R11", "hold result", res_o, held);
    check("R11", "idle valid", {31'd0, valid_o}, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [3:0] md;
      bit mn;
      a = rand_opnd();
      b = ($urandom % 10 == 0) ? a : rand_opnd();
      md = 4'($urandom);
      mn = 1'($urandom);
      run_op(a, b, mn, md, tag_of(a, b, mn, md));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule